// File: doc/BRIEF.md
# Striped Multiport FIFO Queue

This queue moves groups of elements between two pipeline stages that each have several lanes. Every cycle the producer may offer an element on any subset of its write lanes. All elements accepted together form one stripe, and stripes leave the queue in the order they arrived. On the consumer side, read port k always shows lane k of the oldest stripe still held. The consumer may take any subset of the offered lanes in a cycle. Whatever it leaves stays at the head and is offered again in the next cycle. No lane of a younger stripe is shown until the head stripe has been fully drained.

Each lane has its own small storage, indexed by a shared stripe slot. A controller keeps two masks for each stripe: the lanes that were written, and the lanes of the head stripe that have already been read. This gives up some port use after a partial read. In exchange it avoids the cost of a queue that could hand any of the next N elements to any port.

Back-pressure works as follows. On the write side all ready outputs move together. A stripe is taken whole on a clock edge where ready is high and at least one valid is high. Nothing is taken while ready is low. On the read side, lane k leaves on an edge where its valid and ready are both high. Valid never depends on ready in the same cycle.

Top module: `striped_fifo`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `full` is 0, every `rd_valid` bit is 0 and every `wr_ready` bit is 1.
- R2: The element written on write lane k appears on read port k, in bits [k*WIDTH +: WIDTH] of the data buses.
- R3: All `wr_ready` bits carry the same value. That value is 1 exactly when fewer than DEPTH stripes are stored. A write offered while `wr_ready` is low is ignored and never appears at the read ports.
- R4: `rd_valid[k]` is 1 exactly when the queue holds a stripe, lane k of its head stripe was written, and that lane has not yet been read.
- R5: When only some valid lanes of the head stripe are read, those lanes drop their valid in the next cycle. The lanes not read keep their valid and data.
- R6: No lane of a younger stripe is offered while any lane of the head stripe remains, even on read ports that are free.
- R7: A stripe whose offered lanes are all read in one cycle is retired on that edge. The next stripe shows on the read ports in the following cycle, so with all read ports ready, DEPTH stored stripes drain in DEPTH cycles.
- R8: Stripes leave in the order they were accepted, each with its exact lane mask and data.
- R9: `full` is 1 exactly when DEPTH stripes are stored, and `empty` is 1 exactly when none are stored.
- R10: A write and the retirement of the head stripe may happen on the same edge. A queue that is not full then accepts a new stripe on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | LANES | Per-lane write valid; the set of high bits is the stripe mask |
| wr_ready | output | LANES | Per-lane write ready, all bits equal |
| wr_data | input | LANES*WIDTH | Write data, lane k in bits [k*WIDTH +: WIDTH] |
| rd_valid | output | LANES | Per-lane read valid for the head stripe |
| rd_ready | input | LANES | Per-lane read ready |
| rd_data | output | LANES*WIDTH | Read data, lane k in bits [k*WIDTH +: WIDTH] |
| full | output | 1 | DEPTH stripes stored |
| empty | output | 1 | No stripe stored |

## Verification
The main function is tried with four read patterns.

- With all read ports stalled, the queue fills to capacity, and an extra stripe shows whether a write while full is rejected.
- With all read ports ready, the queue drains. The drain time separates whole-stripe retirement from lane-by-lane draining.
- With random per-lane read readiness over random sparse stripes, partial reads occur. This exposes a design that leaks younger lanes early, or that loses or repeats a partly read lane.
- With writes on every cycle while all reads are ready, the test shows whether a retirement and a write on the same edge are both kept.

// File: rtl/stfifo_pkg.sv
package stfifo_pkg;
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned DEPTH_DEF = 4;
  localparam int unsigned WIDTH_DEF = 8;

  function automatic int unsigned ptr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/stfifo_lane.sv
module stfifo_lane #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = stfifo_pkg::ptr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/stfifo_ctrl.sv
module stfifo_ctrl #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = stfifo_pkg::ptr_bits(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] wr_mask,
  input  logic [LANES-1:0] rd_ready,
  output logic [LANES-1:0] head_valid,
  output logic [PW-1:0]    wptr,
  output logic [PW-1:0]    rptr,
  output logic             wr_go,
  output logic             full,
  output logic             empty
);
  logic [LANES-1:0] lane_mask [DEPTH];
  logic [LANES-1:0] taken;
  logic [LANES-1:0] pop;
  logic [CW-1:0]    count;
  logic             retire;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign wr_go      = (|wr_mask) && !full;
  assign head_valid = empty ? '0 : (lane_mask[rptr] & ~taken);
  assign pop        = head_valid & rd_ready;
  assign retire     = !empty && ((head_valid & ~pop) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      taken <= '0;
      for (int i = 0; i < DEPTH; i++) lane_mask[i] <= '0;
    end else begin
      if (wr_go) begin
        lane_mask[wptr] <= wr_mask;
        wptr            <= bump(wptr);
      end
      if (retire) begin
        rptr  <= bump(rptr);
        taken <= '0;
      end else begin
        taken <= taken | pop;
      end
      count <= count + CW'(wr_go) - CW'(retire);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (full && !retire) |=> $stable(wptr));
  assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    empty |-> (head_valid == '0));
  assert_popped_drop_R5: assert property (@(posedge clk) disable iff (rst)
    ((|pop) && !retire) |=> ((head_valid & $past(pop)) == '0));
  assert_head_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!empty && !retire) |=> $stable(rptr));
  assert_retire_move_R7: assert property (@(posedge clk) disable iff (rst)
    retire |=> (rptr == bump($past(rptr))));
endmodule

// File: rtl/striped_fifo.sv
module striped_fifo #(
  parameter int unsigned LANES = stfifo_pkg::LANES_DEF,
  parameter int unsigned DEPTH = stfifo_pkg::DEPTH_DEF,
  parameter int unsigned WIDTH = stfifo_pkg::WIDTH_DEF,
  localparam int unsigned PW = stfifo_pkg::ptr_bits(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       wr_valid,
  output logic [LANES-1:0]       wr_ready,
  input  logic [LANES*WIDTH-1:0] wr_data,
  output logic [LANES-1:0]       rd_valid,
  input  logic [LANES-1:0]       rd_ready,
  output logic [LANES*WIDTH-1:0] rd_data,
  output logic                   full,
  output logic                   empty
);
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic          wr_go;

  stfifo_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .wr_mask(wr_valid), .rd_ready(rd_ready),
    .head_valid(rd_valid), .wptr(wptr), .rptr(rptr), .wr_go(wr_go),
    .full(full), .empty(empty)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    stfifo_lane #(.DEPTH(DEPTH), .WIDTH(WIDTH)) lane_i (
      .clk(clk), .we(wr_go & wr_valid[k]), .waddr(wptr),
      .wdata(wr_data[k*WIDTH +: WIDTH]), .raddr(rptr),
      .rdata(rd_data[k*WIDTH +: WIDTH])
    );
  end

  assign wr_ready = {LANES{~full}};

  assert_ready_uniform_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ready == '0) || (wr_ready == '1));
  assert_write_fill_R10: assert property (@(posedge clk) disable iff (rst)
    ((|wr_valid) && (wr_ready != '0) && (rd_valid == '0)) |=> !empty);
endmodule

// File: tb/striped_fifo_tb.sv
`timescale 1ns/1ps
module striped_fifo_tb_top;
  localparam int L = 4;
  localparam int D = 4;
  localparam int W = 8;

  logic clk = 0;
  logic rst = 1;
  logic [L-1:0]   wr_valid = '0;
  logic [L-1:0]   wr_ready;
  logic [L*W-1:0] wr_data = '0;
  logic [L-1:0]   rd_valid;
  logic [L-1:0]   rd_ready = '0;
  logic [L*W-1:0] rd_data;
  logic           full, empty;

  int checks = 0;
  int errors = 0;
  int mode = 1;          // 0 all ready, 1 none, 2 random, 3 fixed
  logic [L-1:0] fixed_ready = '0;
  bit mon_on = 0;

  logic [L-1:0]   q_mask [$];
  logic [L*W-1:0] q_data [$];
  logic [L-1:0]   consumed = '0;

  always #2 clk = ~clk;

  striped_fifo #(.LANES(L), .DEPTH(D), .WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .full(full), .empty(empty)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [L-1:0] mask, input logic [L*W-1:0] data, output bit acc);
    @(negedge clk);
    wr_valid = mask;
    wr_data  = data;
    acc      = wr_ready[0] && (mask != '0);
    @(posedge clk);
    #1;
    if (acc) begin
      q_mask.push_back(mask);
      q_data.push_back(data);
    end
    wr_valid = '0;
  endtask

  task automatic wait_drain();
    while (q_mask.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        logic [L-1:0] exp_v;
        case (mode)
          0: rd_ready = '1;
          1: rd_ready = '0;
          2: rd_ready = L'($urandom);
          default: rd_ready = fixed_ready;
        endcase
        exp_v = (q_mask.size() != 0) ? (q_mask[0] & ~consumed) : '0;
        check(rd_valid == exp_v, "R4/R5/R6 rd_valid", 64'(rd_valid), 64'(exp_v));
        for (int k = 0; k < L; k++)
          if (exp_v[k])
            check(rd_data[k*W +: W] == q_data[0][k*W +: W], "R2/R8 lane data",
                  64'(rd_data[k*W +: W]), 64'(q_data[0][k*W +: W]));
        check(empty == (q_mask.size() == 0), "R9 empty", 64'(empty), 64'(q_mask.size() == 0));
        check(full == (q_mask.size() == D), "R9 full", 64'(full), 64'(q_mask.size() == D));
        check(wr_ready == {L{q_mask.size() != D}}, "R3 wr_ready", 64'(wr_ready), 64'({L{q_mask.size() != D}}));
        consumed = consumed | (exp_v & rd_ready);
        if (q_mask.size() != 0 && consumed == q_mask[0]) begin
          void'(q_mask.pop_front());
          void'(q_data.pop_front());
          consumed = '0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    int cyc;
    void'($urandom(7));
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(empty == 1'b1, "R1 empty", 64'(empty), 64'd1);
    check(full == 1'b0, "R1 full", 64'(full), 64'd0);
    check(rd_valid == '0, "R1 rd_valid", 64'(rd_valid), 64'd0);
    check(wr_ready == '1, "R1 wr_ready", 64'(wr_ready), 64'hF);
    mon_on = 1;

    // fill with reads stalled; fifth stripe must be ignored (R3)
    mode = 1;
    for (int i = 0; i < D; i++) begin
      push('1, 32'(32'h11111111 * (i + 1)), acc);
      check(acc, "R3 accept while room", 64'(acc), 64'd1);
    end
    push(4'b0101, 32'hDEADBEEF, acc);
    check(!acc, "R3 write while full ignored", 64'(acc), 64'd0);

    // R7: full stripes drain one per cycle
    @(posedge clk); #1;
    mode = 0;
    cyc = 0;
    forever begin
      @(negedge clk);
      if (empty) break;
      cyc++;
    end
    check(cyc == D, "R7 drain cycles", 64'(cyc), 64'(D));

    // R5/R6 directed partial read of {a,b} then {c,d}
    @(posedge clk); #1;
    mode = 3;
    fixed_ready = '0;
    push(4'b0011, 32'h0000B0A0, acc);
    push(4'b0011, 32'h0000D0C0, acc);
    @(posedge clk); #1;
    fixed_ready = 4'b0001;
    @(posedge clk); #1;
    fixed_ready = 4'b0001;   // lane 0 free, must stay idle (R6)
    @(posedge clk); #1;
    @(posedge clk); #1;
    fixed_ready = 4'b0010;
    @(posedge clk); #1;
    fixed_ready = '1;
    wait_drain();

    // random sparse stripes with random read readiness (R2 R4 R5 R6 R8)
    @(posedge clk); #1;
    mode = 2;
    for (int i = 0; i < 40; i++) begin
      logic [L-1:0] m;
      m = L'($urandom);
      if (m == '0) m = 4'b1000;
      push(m, $urandom, acc);
      if (!acc) i--;
    end
    wait_drain();

    // R10 back-to-back writes with all reads ready
    @(posedge clk); #1;
    mode = 0;
    for (int i = 0; i < 12; i++) begin
      push(L'(i + 1), 32'(32'hA5000000 + i), acc);
      check(acc, "R10 streaming accept", 64'(acc), 64'd1);
    end
    wait_drain();
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule